// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

This block is a free-running tick source of the kind used to give software a steady time base. A 24-bit counter moves down by one on every cycle of the bus clock. When it has reached zero it reloads from a programmable reload register and raises a one-cycle interrupt request. The request period is therefore the reload value plus one cycles. A reload of 7999 on an 80 MHz bus gives a 10 kHz tick.

Software sees three things. The first is a mode register with an enable bit, an interrupt-enable bit and a clock-source bit. The second is a 24-bit reload register. The third is a current-value register: any write to it clears the count. The mode register read path also returns a sticky wrap flag. Reading the mode register clears that flag, and so does writing the current value.

The usual start-up order is:
1. Disable the timer.
2. Load the reload value.
3. Clear the current value.
4. Write mode 7, which sets enable, interrupt enable and the internal clock source.

Only the internal bus-clock source is implemented. With the source bit clear, the counter does not advance.

Top module: `periodic_tick_timer`

## Requirements
- R1: After an asynchronous reset, the following all read zero: the count, the mode bits, the wrap flag and the interrupt request.
- R2: The mode read word carries enable in bit 0, interrupt enable in bit 1, clock source in bit 2 and the wrap flag in bit 16. All other bits read zero.
- R3: The count decreases by exactly one per clock when all three conditions hold: enable is 1, clock source is 1, and the reload value is nonzero.
- R4: While running, a clock edge that finds the count at zero loads the reload value and sets the wrap flag, so wraps recur every reload+1 cycles.
- R5: On each wrap, the interrupt request is high for exactly one cycle when interrupt enable is 1. It stays low when interrupt enable is 0.
- R6: A write to the current-value register, whatever the data, sets the count to zero and clears the wrap flag. It takes priority over counting.
- R7: A read strobe on the mode register returns the flag and clears it at the following edge. A wrap in the same cycle leaves the flag set.
- R8: A reload value of zero stops counting and produces no wrap and no interrupt.
- R9: With clock source 0, the count holds even when enable is 1.
- R10: With enable 0, the count holds its value.
- R11: A new reload value does not disturb the count in progress. It is used from the next wrap onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Write strobe for the mode register |
| mode_wdata_i | input | 3 | Mode write data: bit 0 enable, bit 1 interrupt enable, bit 2 clock source |
| mode_re_i | input | 1 | Read strobe for the mode register (clears the wrap flag) |
| mode_rdata_o | output | 32 | Mode read word with the wrap flag in bit 16 |
| reload_we_i | input | 1 | Write strobe for the reload register |
| reload_wdata_i | input | 24 | Reload value |
| cur_we_i | input | 1 | Write strobe for the current-value register (data ignored) |
| cur_o | output | 24 | Current count |
| irq_o | output | 1 | Interrupt request, one-cycle pulse per wrap |

## Verification
Directed sequences check four things:
- The reset state.
- The exact wrap period for a small reload, found by counting the cycles between two pulses.
- The effect of each gating bit taken alone: clock source off, enable off, and a zero reload. This shows which condition actually stops the count.
- The corner cases at a read edge and at a reload change: a read-clear of the flag, and a reload rewritten in the middle of a count, which must not bend the current period.

A long constrained-random run then mixes mode writes, clears, reads and small reloads, including zero. It compares every cycle against a bench model. This exposes ordering faults such as a clear losing to a wrap, or a flag set being lost to a read in the same cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned EN_POS   = 0;
  localparam int unsigned IE_POS   = 1;
  localparam int unsigned SRC_POS  = 2;
  localparam int unsigned FLAG_POS = 16;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } tick_mode_t;
endpackage

// File: rtl/tick_cfg_reg.sv
module tick_cfg_reg
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_we_i,
  input  logic [MODE_W-1:0]    mode_wdata_i,
  input  logic                 reload_we_i,
  input  logic [CNT_W-1:0]     reload_wdata_i,
  output tick_mode_t           mode_o,
  output logic [CNT_W-1:0]     reload_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= '0;
      reload_o <= '0;
    end else begin
      if (mode_we_i)   mode_o   <= tick_mode_t'(mode_wdata_i);
      if (reload_we_i) reload_o <= reload_wdata_i;
    end
  end
endmodule

// File: rtl/tick_down_cnt.sv
module tick_down_cnt #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic at_zero;
  assign at_zero = (cnt_o == '0);
  // a clear suppresses the wrap in the same cycle
  assign wrap_o  = run_i && at_zero && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (clr_i)    cnt_o <= '0;
    else if (run_i)    cnt_o <= at_zero ? reload_i : cnt_o - 1'b1;
  end
endmodule

// File: rtl/tick_event.sv
module tick_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic ie_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= wrap_i && ie_i;
      if (wrap_i)     flag_o <= 1'b1;  // set wins over read-clear
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_we_i,
  input  logic [MODE_W-1:0]   mode_wdata_i,
  input  logic                mode_re_i,
  output logic [DATA_W-1:0]   mode_rdata_o,
  input  logic                reload_we_i,
  input  logic [CNT_W-1:0]    reload_wdata_i,
  input  logic                cur_we_i,
  output logic [CNT_W-1:0]    cur_o,
  output logic                irq_o
);
  tick_mode_t       mode_q;
  logic [CNT_W-1:0] reload_q;
  logic             run, wrap, flag_q;

  tick_cfg_reg #(.CNT_W(CNT_W)) i_cfg (
    .clk_i, .rst_ni, .mode_we_i, .mode_wdata_i, .reload_we_i, .reload_wdata_i,
    .mode_o(mode_q), .reload_o(reload_q)
  );

  // only the internal bus-clock source advances the counter
  assign run = mode_q.en && mode_q.src && (reload_q != '0);

  tick_down_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .run_i(run), .clr_i(cur_we_i), .reload_i(reload_q),
    .cnt_o(cur_o), .wrap_o(wrap)
  );

  tick_event i_evt (
    .clk_i, .rst_ni, .wrap_i(wrap), .ie_i(mode_q.ie),
    .clr_i(cur_we_i || mode_re_i), .flag_o(flag_q), .irq_o
  );

  always_comb begin
    mode_rdata_o           = '0;
    mode_rdata_o[EN_POS]   = mode_q.en;
    mode_rdata_o[IE_POS]   = mode_q.ie;
    mode_rdata_o[SRC_POS]  = mode_q.src;
    mode_rdata_o[FLAG_POS] = flag_q;
  end
endmodule

// File: rtl/periodic_tick_timer_chk.sv
module periodic_tick_timer_chk #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cur_we_i,
  input logic [DATA_W-1:0] mode_rdata_o,
  input logic [CNT_W-1:0]  cur_o,
  input logic [CNT_W-1:0]  reload_q,
  input logic              irq_o
);
  logic en, ie, src, flg;
  assign en  = mode_rdata_o[0];
  assign ie  = mode_rdata_o[1];
  assign src = mode_rdata_o[2];
  assign flg = mode_rdata_o[16];

  AST_DEC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && src && reload_q != '0 && cur_o != '0 && !cur_we_i) |=> (cur_o == $past(cur_o) - 1'b1)); // R3
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flg); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |=> !irq_o); // R5
  AST_CUR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_we_i |=> (cur_o == '0 && !flg)); // R6
  AST_ZERO_RELOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_q == '0 && !cur_we_i) |=> ($stable(cur_o) && !irq_o)); // R8
  AST_NO_SRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src && !cur_we_i) |=> $stable(cur_o)); // R9
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cur_we_i) |=> $stable(cur_o)); // R10
endmodule

bind periodic_tick_timer periodic_tick_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cur_we_i(cur_we_i), .mode_rdata_o(mode_rdata_o),
  .cur_o(cur_o), .reload_q(reload_q), .irq_o(irq_o)
);

// File: tb/test_periodic_tick_timer.sv
module test_periodic_tick_timer;
  localparam int CNT_W = 24;
  localparam int DATA_W = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mode_we_i = 0, mode_re_i = 0, reload_we_i = 0, cur_we_i = 0;
  logic [2:0] mode_wdata_i = '0;
  logic [CNT_W-1:0] reload_wdata_i = '0;
  logic [DATA_W-1:0] mode_rdata_o;
  logic [CNT_W-1:0] cur_o;
  logic irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  periodic_tick_timer i_periodic_tick_timer (.*);

  always #4 clk_i = ~clk_i;

  // bench model built from R3..R11
  logic [CNT_W-1:0] m_cnt, m_rel;
  logic m_en, m_ie, m_src, m_flag, m_irq;
  logic m_run, m_wrap;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= '0; m_rel <= '0; m_en <= 0; m_ie <= 0; m_src <= 0; m_flag <= 0; m_irq <= 0;
    end else begin
      m_run  = m_en && m_src && (m_rel != 0);
      m_wrap = m_run && (m_cnt == 0) && !cur_we_i;
      m_irq <= m_wrap && m_ie;
      if (cur_we_i) m_cnt <= '0;
      else if (m_run) m_cnt <= (m_cnt == 0) ? m_rel : m_cnt - 1'b1;
      if (m_wrap) m_flag <= 1'b1;
      else if (cur_we_i || mode_re_i) m_flag <= 1'b0;
      if (mode_we_i) {m_src, m_ie, m_en} <= mode_wdata_i;
      if (reload_we_i) m_rel <= reload_wdata_i;
    end
  end

  function automatic logic [DATA_W-1:0] exp_rdata();
    logic [DATA_W-1:0] w = '0;
    w[0] = m_en; w[1] = m_ie; w[2] = m_src; w[16] = m_flag;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model(string req);
    check({req, " count"}, 32'(cur_o), 32'(m_cnt));
    check({req, " irq"}, 32'(irq_o), 32'(m_irq));
    check({req, " rdata"}, mode_rdata_o, exp_rdata());
  endtask

  task automatic step(string req, bit cw = 0, bit mw = 0, logic [2:0] md = 0,
                      bit mr = 0, bit rw = 0, logic [CNT_W-1:0] rd = 0);
    cur_we_i = cw; mode_we_i = mw; mode_wdata_i = md; mode_re_i = mr;
    reload_we_i = rw; reload_wdata_i = rd;
    @(negedge clk_i);
    cur_we_i = 0; mode_we_i = 0; mode_re_i = 0; reload_we_i = 0;
    cmp_model(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed, last, gap;
    seed = 32'h1234abcd;
    void'($urandom(seed));
    #3;
    // R1 reset state
    check("R1 count", 32'(cur_o), 0);
    check("R1 rdata", mode_rdata_o, 0);
    check("R1 irq", 32'(irq_o), 0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    cmp_model("R1");

    // start-up order, reload 4 -> period 5 (R4)
    step("R4", .mw(1), .md(3'b000));
    step("R4", .rw(1), .rd(4));
    step("R6", .cw(1));
    step("R2", .mw(1), .md(3'b111));
    check("R2 readback", mode_rdata_o & 32'h7, 32'h7);
    last = -1; gap = 0;
    for (int i = 0; i < 20; i++) begin
      step("R4");
      if (irq_o) begin
        if (last >= 0 && gap == 0) gap = i - last;
        last = i;
      end
    end
    check("R4 period", 32'(gap), 5);
    check("R4 flag set", 32'(mode_rdata_o[16]), 1);

    // R7 read-clear
    mode_re_i = 1; #1;
    check("R7 read shows flag", 32'(mode_rdata_o[16]), 1);
    @(negedge clk_i); mode_re_i = 0;
    cmp_model("R7");
    if (!irq_o) check("R7 flag cleared", 32'(mode_rdata_o[16]), 0);

    // R11 reload change mid count
    step("R11", .cw(1));
    step("R11");            // wrap: loads 4
    step("R11", .rw(1), .rd(9));
    check("R11 count kept", 32'(cur_o), 3);
    for (int i = 0; i < 4; i++) step("R11");
    check("R11 new reload", 32'(cur_o), 9);

    // R9 clock source off
    step("R9", .mw(1), .md(3'b011));
    for (int i = 0; i < 3; i++) step("R9");
    check("R9 hold", 32'(cur_o), 32'(m_cnt));
    // R10 enable off
    step("R10", .mw(1), .md(3'b110));
    for (int i = 0; i < 3; i++) step("R10");
    // R8 zero reload
    step("R8", .mw(1), .md(3'b111), .rw(1), .rd(0));
    step("R8", .cw(1));
    for (int i = 0; i < 5; i++) begin
      step("R8");
      check("R8 no irq", 32'(irq_o), 0);
    end
    check("R8 count zero", 32'(cur_o), 0);
    // R5 masked interrupt
    step("R5", .mw(1), .md(3'b101), .rw(1), .rd(2));
    for (int i = 0; i < 10; i++) begin
      step("R5");
      check("R5 masked", 32'(irq_o), 0);
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit cw, mw, mr, rw;
      logic [2:0] md;
      logic [CNT_W-1:0] rd;
      cw = ($urandom_range(99) < 3);
      mw = ($urandom_range(99) < 4);
      md = ($urandom_range(3) == 0) ? 3'($urandom()) : 3'b111;
      mr = ($urandom_range(99) < 10);
      rw = ($urandom_range(99) < 3);
      rd = ($urandom_range(9) == 0) ? '0 : CNT_W'($urandom_range(20));
      step("R3", cw, mw, md, mr, rw, rd);
    end
    finish_run();
  end
endmodule